// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores one received Ethernet frame into a ring of receive buffer descriptors. A frame is announced by a start pulse carrying its byte length and its 32-bit CRC, and its payload then arrives one byte per accepted handshake. The engine appends the four CRC bytes to the payload and spreads the result over consecutive empty descriptors, each holding at most the programmed buffer size. It writes back a length and a flags halfword for every descriptor it fills, follows the wrap flag back to the ring base, and marks frames that were cut short or that exceed the size limit.

Descriptors are reached through a small port. `desc_addr` names the current descriptor and `desc_rd_flags` returns its flags in the same cycle. Data bytes leave on `data_wr_*` as an offset into the buffer of the descriptor at `desc_addr`. A status bit, `rx_active`, says whether the ring can take a frame. A pulse on `rx_arm` samples it from the current descriptor, and after every frame it is updated from the descriptor the pointer then names.

The control is a five-state machine. ST_IDLE waits for a start pulse: with `rx_active` set it moves to ST_NEXT, otherwise to ST_DRAIN. ST_NEXT inspects the current descriptor: bytes left and the descriptor empty go to ST_FILL; bytes left and the descriptor in use go to ST_DRAIN; nothing left goes to ST_DRAIN while input bytes are still owed, else to ST_IDLE. ST_FILL writes one byte per cycle and moves to ST_CLOSE after the buffer's last byte. ST_CLOSE writes the descriptor back, raises an event, advances the pointer and returns to ST_NEXT. ST_DRAIN accepts and discards input bytes until none are owed, then returns to ST_IDLE.

Top module: `rxr_engine`

## Requirements
- R1: A frame that starts while `rx_active` is 0 produces no data write, no descriptor write and no event, and all of its input bytes are still accepted.
- R2: The stored size is the frame length plus 4. When it exceeds MAX_FRAME, it is cut to MAX_FRAME, and the truncated flag (bit 0) and the length-error flag (bit 5) are both set in the last descriptor.
- R3: When the stored size exceeds `cfg_size_limit`, the length-error flag (bit 5) is set in the last descriptor.
- R4: Each descriptor receives min(bytes remaining, buffer size) bytes at offsets 0 upward, and its written length equals that count. The buffer size is `cfg_buf_max` AND 0x3FF0, and a result of zero acts as 16.
- R5: The stored byte stream is the payload (truncated to stored size minus 4) followed by the CRC, most significant byte first. The CRC bytes may be split across two descriptors.
- R6: Every written-back descriptor has the empty flag (bit 15) cleared and its other input flags kept. Only the final one gets the last flag (bit 11) and the error flags, and it raises `ev_frame`. Every other one raises `ev_buf`.
- R7: After a write-back, the pointer moves to the ring base when the descriptor's wrap flag (bit 13) is set, and otherwise moves 8 bytes forward.
- R8: When a descriptor without the empty flag is met partway through a frame, the rest of the frame is accepted and discarded, and `rx_active` becomes 0.
- R9: At the end of a frame, `rx_active` equals the empty flag of the descriptor at the new pointer. An `rx_arm` pulse in ST_IDLE copies the empty flag of the current descriptor. Reset clears it.
- R10: The ring base has its two low bits forced to zero, and reset places the pointer at that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ring_base | input | ADDR_W | Ring base address (low 2 bits ignored) |
| cfg_buf_max | input | 16 | Maximum bytes per buffer (masked with 0x3FF0) |
| cfg_size_limit | input | 16 | Stored-size limit for the length-error flag |
| rx_arm | input | 1 | Pulse: sample ring readiness from the current descriptor |
| frm_start | input | 1 | Pulse: a frame begins |
| frm_len | input | LEN_W | Payload byte count of the frame |
| frm_crc | input | 32 | CRC appended after the payload |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Engine accepts a payload byte this cycle |
| desc_addr | output | ADDR_W | Address of the current descriptor |
| desc_rd_flags | input | 16 | Flags of the descriptor at desc_addr |
| desc_wr_en | output | 1 | Descriptor write-back strobe |
| desc_wr_len | output | 16 | Length written back |
| desc_wr_flags | output | 16 | Flags written back |
| data_wr_en | output | 1 | Buffer byte write strobe |
| data_wr_off | output | 16 | Byte offset in the current descriptor's buffer |
| data_wr_byte | output | 8 | Byte written |
| ev_buf | output | 1 | Pulse: a non-final buffer was closed |
| ev_frame | output | 1 | Pulse: the final buffer of a frame was closed |
| rx_active | output | 1 | Ring ready to accept a frame |

## Verification
The hardest situation to reach is a ring that fills partway through a frame while the CRC tail is about to straddle a buffer boundary. Both depend on the pointer's position in the ring, and the pointer is only visible as the result of earlier frames. The bench keeps its own model of the pointer. Before each frame it rewrites the descriptor table so that only the current descriptor and the one after it are empty, or so that all of them are, and it picks frame lengths of 14 and 12 against 16-byte buffers to force a split and an exact fit. Random lengths, buffer sizes and limits then carry the pointer around the wrap several times.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    // Bit positions in the descriptor flags halfword
    localparam int unsigned FLG_EMPTY = 15;
    localparam int unsigned FLG_WRAP  = 13;
    localparam int unsigned FLG_LAST  = 11;
    localparam int unsigned FLG_LGV   = 5;
    localparam int unsigned FLG_TRUNC = 0;

    localparam logic [15:0] BUF_MASK    = 16'h3FF0;
    localparam logic [15:0] BUF_MIN     = 16'd16;
    localparam int unsigned DESC_STRIDE = 8;
    localparam int unsigned CRC_BYTES   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEXT,
        ST_FILL,
        ST_CLOSE,
        ST_DRAIN
    } rxr_state_e;
endpackage

// File: rtl/rxr_chunk.sv
module rxr_chunk
    import rxr_pkg::*;
#(
    parameter int unsigned SZ_W = 15
) (
    input  logic [SZ_W-1:0] remain,
    input  logic [15:0]     buf_max,
    output logic [15:0]     chunk
);
    logic [15:0] eff;

    always_comb begin
        eff = buf_max & BUF_MASK;
        if (eff == 16'd0) eff = BUF_MIN;
        if (32'(remain) < 32'(eff)) chunk = 16'(remain);
        else                        chunk = eff;
    end
endmodule

// File: rtl/rxr_size_calc.sv
module rxr_size_calc
    import rxr_pkg::*;
#(
    parameter int unsigned LEN_W     = 14,
    parameter int unsigned MAX_FRAME = 2048
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic [15:0]      size_limit,
    output logic [LEN_W:0]   stored_size,
    output logic             trunc,
    output logic             len_err
);
    localparam int unsigned SZ_W = LEN_W + 1;

    logic [SZ_W-1:0] full;

    always_comb begin
        full        = {1'b0, frame_len} + SZ_W'(CRC_BYTES);
        trunc       = 32'(full) > MAX_FRAME;
        stored_size = trunc ? SZ_W'(MAX_FRAME) : full;
        len_err     = trunc || (32'(stored_size) > 32'(size_limit));
    end
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] base_m;

    assign base_m = base_in & ~ADDR_W'(3);

    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= base_m;
        else if (advance) ptr <= wrap ? base_m : ptr + ADDR_W'(DESC_STRIDE);
    end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LEN_W     = 14,
    parameter int unsigned MAX_FRAME = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [15:0]       cfg_buf_max,
    input  logic [15:0]       cfg_size_limit,
    input  logic              rx_arm,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [31:0]       frm_crc,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic [15:0]       desc_rd_flags,
    output logic              desc_wr_en,
    output logic [15:0]       desc_wr_len,
    output logic [15:0]       desc_wr_flags,
    output logic              data_wr_en,
    output logic [15:0]       data_wr_off,
    output logic [7:0]        data_wr_byte,
    output logic              ev_buf,
    output logic              ev_frame,
    output logic              rx_active
);
    localparam int unsigned SZ_W = LEN_W + 1;
    localparam logic [15:0] M_EMPTY = 16'(1) << FLG_EMPTY;
    localparam logic [15:0] M_LAST  = 16'(1) << FLG_LAST;

    rxr_state_e state, state_nxt;

    logic [SZ_W-1:0]  remain;
    logic [LEN_W-1:0] in_left;
    logic [15:0]      buf_left;
    logic [15:0]      cnt;
    logic [31:0]      crc_q;
    logic             trunc_q, lgv_q, active_q;

    logic [SZ_W-1:0]  stored_size;
    logic             trunc_c, lgv_c;
    logic [15:0]      chunk;
    logic             desc_empty, is_crc, byte_go, in_take, frame_done;
    logic [7:0]       crc_byte;

    rxr_size_calc #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_size (
        .frame_len   (frm_len),
        .size_limit  (cfg_size_limit),
        .stored_size (stored_size),
        .trunc       (trunc_c),
        .len_err     (lgv_c)
    );

    rxr_chunk #(.SZ_W(SZ_W)) u_chunk (
        .remain  (remain),
        .buf_max (cfg_buf_max),
        .chunk   (chunk)
    );

    rxr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_in (cfg_ring_base),
        .advance (state == ST_CLOSE),
        .wrap    (desc_rd_flags[FLG_WRAP]),
        .ptr     (desc_addr)
    );

    assign desc_empty = desc_rd_flags[FLG_EMPTY];
    assign is_crc     = remain <= SZ_W'(CRC_BYTES);
    assign frame_done = remain == '0;
    assign in_ready   = ((state == ST_FILL) && !is_crc) ||
                        ((state == ST_DRAIN) && (in_left != '0));
    assign in_take    = in_ready && in_valid;
    assign byte_go    = (state == ST_FILL) && (is_crc || in_valid);

    always_comb begin
        unique case (remain[2:0])
            3'd4:    crc_byte = crc_q[31:24];
            3'd3:    crc_byte = crc_q[23:16];
            3'd2:    crc_byte = crc_q[15:8];
            default: crc_byte = crc_q[7:0];
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (frm_start) state_nxt = active_q ? ST_NEXT : ST_DRAIN;
            ST_NEXT: begin
                if (frame_done)      state_nxt = (in_left != '0) ? ST_DRAIN : ST_IDLE;
                else if (desc_empty) state_nxt = ST_FILL;
                else                 state_nxt = ST_DRAIN;
            end
            ST_FILL:  if (byte_go && buf_left == 16'd1) state_nxt = ST_CLOSE;
            ST_CLOSE: state_nxt = ST_NEXT;
            ST_DRAIN: if (in_left == '0 || (in_left == LEN_W'(1) && in_take))
                          state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            in_left  <= '0;
            buf_left <= '0;
            cnt      <= '0;
            crc_q    <= '0;
            trunc_q  <= 1'b0;
            lgv_q    <= 1'b0;
            active_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frm_start) begin
                        remain  <= stored_size;
                        in_left <= frm_len;
                        crc_q   <= frm_crc;
                        trunc_q <= trunc_c;
                        lgv_q   <= lgv_c;
                    end else if (rx_arm) begin
                        active_q <= desc_empty;
                    end
                end
                ST_NEXT: begin
                    if (frame_done) begin
                        active_q <= desc_empty;
                    end else if (desc_empty) begin
                        buf_left <= chunk;
                        cnt      <= '0;
                    end else begin
                        active_q <= 1'b0;
                    end
                end
                ST_FILL: begin
                    if (byte_go) begin
                        remain   <= remain - SZ_W'(1);
                        buf_left <= buf_left - 16'd1;
                        cnt      <= cnt + 16'd1;
                    end
                    if (in_take) in_left <= in_left - LEN_W'(1);
                end
                ST_DRAIN: if (in_take) in_left <= in_left - LEN_W'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        data_wr_en    = byte_go;
        data_wr_off   = cnt;
        data_wr_byte  = is_crc ? crc_byte : in_data;
        desc_wr_en    = state == ST_CLOSE;
        desc_wr_len   = cnt;
        desc_wr_flags = desc_rd_flags & ~M_EMPTY;
        if (frame_done)
            desc_wr_flags = desc_wr_flags | M_LAST |
                            (16'(trunc_q) << FLG_TRUNC) | (16'(lgv_q) << FLG_LGV);
        ev_frame      = (state == ST_CLOSE) && frame_done;
        ev_buf        = (state == ST_CLOSE) && !frame_done;
        rx_active     = active_q;
    end
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk
    import rxr_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_ring_base,
    input logic [15:0]       cfg_buf_max,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [15:0]       desc_rd_flags,
    input logic              desc_wr_en,
    input logic [15:0]       desc_wr_len,
    input logic [15:0]       desc_wr_flags,
    input logic              data_wr_en,
    input logic [15:0]       data_wr_off,
    input logic              ev_buf,
    input logic              ev_frame
);
    logic [15:0] eff;
    always_comb begin
        eff = cfg_buf_max & BUF_MASK;
        if (eff == 16'd0) eff = BUF_MIN;
    end

    a_r6_final_close: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |-> desc_wr_en && desc_wr_flags[FLG_LAST] && !desc_wr_flags[FLG_EMPTY]);

    a_r6_mid_close: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf |-> desc_wr_en && !desc_wr_flags[FLG_LAST] && !desc_wr_flags[FLG_EMPTY]
                   && !desc_wr_flags[FLG_TRUNC] && !desc_wr_flags[FLG_LGV]);

    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |-> $countones({ev_buf, ev_frame}) == 1);

    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en |-> desc_wr_len != 16'd0 && desc_wr_len <= eff);

    a_r4_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_en |-> data_wr_off < eff);

    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        desc_addr[1:0] == 2'b00);

    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en && !desc_rd_flags[FLG_WRAP] |=>
            desc_addr == $past(desc_addr) + ADDR_W'(DESC_STRIDE));

    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr_en && desc_rd_flags[FLG_WRAP] |=>
            desc_addr == (cfg_ring_base & ~ADDR_W'(3)));
endmodule

bind rxr_engine rxr_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ring_base (cfg_ring_base),
    .cfg_buf_max   (cfg_buf_max),
    .desc_addr     (desc_addr),
    .desc_rd_flags (desc_rd_flags),
    .desc_wr_en    (desc_wr_en),
    .desc_wr_len   (desc_wr_len),
    .desc_wr_flags (desc_wr_flags),
    .data_wr_en    (data_wr_en),
    .data_wr_off   (data_wr_off),
    .ev_buf        (ev_buf),
    .ev_frame      (ev_frame)
);

// File: tb/tb_rxr_engine.sv
module tb_rxr_engine;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 14;
    localparam int MAXF   = 64;
    localparam int RING_N = 6;
    localparam logic [15:0] BASE_RAW = 16'h0107;
    localparam logic [15:0] BASE_M   = 16'h0104;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [15:0]       cfg_buf_max = 16'd16, cfg_size_limit = 16'd100;
    logic              rx_arm = 1'b0, frm_start = 1'b0, in_valid = 1'b0;
    logic [LEN_W-1:0]  frm_len = '0;
    logic [31:0]       frm_crc = '0;
    logic [7:0]        in_data = '0;
    logic              in_ready, desc_wr_en, data_wr_en, ev_buf, ev_frame, rx_active;
    logic [ADDR_W-1:0] desc_addr;
    logic [15:0]       desc_rd_flags, desc_wr_len, desc_wr_flags, data_wr_off;
    logic [7:0]        data_wr_byte;

    rxr_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_FRAME(MAXF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(BASE_RAW), .cfg_buf_max(cfg_buf_max),
        .cfg_size_limit(cfg_size_limit), .rx_arm(rx_arm), .frm_start(frm_start),
        .frm_len(frm_len), .frm_crc(frm_crc), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .desc_addr(desc_addr), .desc_rd_flags(desc_rd_flags),
        .desc_wr_en(desc_wr_en), .desc_wr_len(desc_wr_len), .desc_wr_flags(desc_wr_flags),
        .data_wr_en(data_wr_en), .data_wr_off(data_wr_off), .data_wr_byte(data_wr_byte),
        .ev_buf(ev_buf), .ev_frame(ev_frame), .rx_active(rx_active)
    );

    // Descriptor flags memory
    logic [15:0]       dmem [RING_N];
    logic              refill_req = 1'b1;
    logic [RING_N-1:0] refill_mask = '1;

    function automatic int didx(logic [15:0] a);
        int i;
        i = int'((a - BASE_M) >> 3);
        if (i < 0 || i >= RING_N) i = 0;
        return i;
    endfunction

    always_comb desc_rd_flags = dmem[didx(desc_addr)];

    always @(posedge clk) begin
        if (refill_req) begin
            for (int i = 0; i < RING_N; i++)
                dmem[i] <= (refill_mask[i] ? 16'h8000 : 16'h0000) |
                           ((i == RING_N - 1) ? 16'h2000 : 16'h0000);
        end else if (desc_wr_en) begin
            dmem[didx(desc_addr)] <= desc_wr_flags;
        end
    end

    // Monitor of what the design writes
    logic [31:0] act_d[$];
    logic [47:0] act_w[$];
    int act_buf = 0, act_frm = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (data_wr_en) act_d.push_back({desc_addr, data_wr_off[7:0], data_wr_byte});
            if (desc_wr_en) act_w.push_back({desc_addr, desc_wr_len, desc_wr_flags});
            if (ev_buf)   act_buf++;
            if (ev_frame) act_frm++;
        end
    end

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model state
    logic [15:0] m_ptr;
    bit          m_active;
    logic [31:0] exp_d[$];
    logic [47:0] exp_w[$];
    int          exp_buf, exp_frm;
    logic [7:0]  pay [128];

    function automatic int eff_of(logic [15:0] m);
        int e;
        e = int'(m & 16'h3FF0);
        return (e == 0) ? 16 : e;
    endfunction

    task automatic model(int len, logic [31:0] crc, int meff, int lim);
        int sz, p, remain, k, n, i;
        bit tr, lg;
        logic [15:0] cp [RING_N];
        logic [15:0] f;
        logic [7:0]  b;
        exp_d.delete(); exp_w.delete(); exp_buf = 0; exp_frm = 0;
        for (int j = 0; j < RING_N; j++) cp[j] = dmem[j];
        if (!m_active) return;
        sz = len + 4; tr = 0; lg = 0;
        if (sz > MAXF) begin sz = MAXF; tr = 1; lg = 1; end
        if (sz > lim) lg = 1;
        p = sz - 4; remain = sz; k = 0;
        while (remain > 0) begin
            i = didx(m_ptr);
            if (!cp[i][15]) begin m_active = 0; return; end
            n = (remain < meff) ? remain : meff;
            for (int j = 0; j < n; j++) begin
                b = (k < p) ? pay[k] : 8'(crc >> (8 * (3 - (k - p))));
                exp_d.push_back({m_ptr, 8'(j), b});
                k++;
            end
            remain -= n;
            f = cp[i] & 16'h7FFF;
            if (remain == 0) f = f | 16'h0800 | 16'(tr) | (16'(lg) << 5);
            exp_w.push_back({m_ptr, 16'(n), f});
            cp[i] = f;
            if (remain == 0) exp_frm++; else exp_buf++;
            m_ptr = cp[i][13] ? BASE_M : m_ptr + 16'd8;
        end
        m_active = cp[didx(m_ptr)][15];
    endtask

    task automatic refill(logic [RING_N-1:0] mask);
        @(negedge clk); refill_mask = mask; refill_req = 1'b1;
        @(negedge clk); refill_req = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk); rx_arm = 1'b1;
        m_active = dmem[didx(m_ptr)][15];
        @(negedge clk); rx_arm = 1'b0;
    endtask

    task automatic run_frame(int len, logic [15:0] mrbr, int lim, string tag);
        int sd, sw, b0, f0, i, nd, nw;
        logic [31:0] crc;
        bit go, ok;
        cfg_buf_max = mrbr; cfg_size_limit = 16'(lim);
        for (int j = 0; j < 128; j++) pay[j] = 8'($urandom);
        crc = $urandom;
        model(len, crc, eff_of(mrbr), lim);
        sd = act_d.size(); sw = act_w.size(); b0 = act_buf; f0 = act_frm;
        @(negedge clk);
        frm_start = 1'b1; frm_len = LEN_W'(len); frm_crc = crc;
        @(negedge clk);
        frm_start = 1'b0;
        i = 0;
        while (i < len) begin
            go = ($urandom % 4) != 0;
            in_valid = go; in_data = pay[i];
            if (go && in_ready) i++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
        // R4 R5: byte stream into buffers
        nd = act_d.size() - sd;
        ok = (nd == exp_d.size());
        for (int j = 0; ok && j < nd; j++) ok = (act_d[sd + j] == exp_d[j]);
        chk(ok, "R5", {tag, " data stream"}, nd, exp_d.size());
        // R6 R2 R3: descriptor write-backs
        nw = act_w.size() - sw;
        ok = (nw == exp_w.size());
        for (int j = 0; ok && j < nw; j++) begin
            ok = (act_w[sw + j] == exp_w[j]);
            if (!ok) chk(0, "R6", {tag, " descriptor"}, act_w[sw + j], exp_w[j]);
        end
        if (nw != exp_w.size()) chk(0, "R6", {tag, " descriptor count"}, nw, exp_w.size());
        else if (ok) chk(1, "R6", {tag, " descriptor"}, 0, 0);
        chk((act_buf - b0) == exp_buf, "R6", {tag, " buffer events"}, act_buf - b0, exp_buf);
        chk((act_frm - f0) == exp_frm, "R6", {tag, " frame events"}, act_frm - f0, exp_frm);
        chk(rx_active == m_active, "R9", {tag, " rx_active"}, rx_active, m_active);
        chk(desc_addr == m_ptr, "R7", {tag, " pointer"}, desc_addr, m_ptr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int i0, i1;
        logic [RING_N-1:0] m;
        void'($urandom(32'd20240611));
        m_ptr = BASE_M; m_active = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1; refill_req = 1'b0;
        @(negedge clk);
        chk(desc_addr == BASE_M, "R10", "reset pointer", desc_addr, BASE_M);
        chk(rx_active == 1'b0, "R9", "reset rx_active", rx_active, 0);
        chk(data_wr_en == 1'b0 && desc_wr_en == 1'b0, "R1", "idle writes", data_wr_en, 0);

        // R1: dropped while inactive, bytes still consumed
        run_frame(10, 16'd16, 100, "R1 drop");
        arm();
        chk(rx_active == 1'b1, "R9", "arm", rx_active, 1);
        // R5: CRC split 2+2 across two buffers
        run_frame(14, 16'd16, 100, "R5 split");
        // R4: exact fit in one buffer
        run_frame(12, 16'd16, 100, "R4 exact");
        // R2: truncation at MAX frame
        run_frame(70, 16'd16, 100, "R2 trunc");
        // R3: limit only
        run_frame(30, 16'd32, 20, "R3 limit");
        // R4: masked and zero buffer size
        run_frame(20, 16'h000F, 100, "R4 zero");
        run_frame(40, 16'hC01F, 100, "R4 mask");
        // R8: ring full partway
        i0 = didx(m_ptr); i1 = (i0 == RING_N - 1) ? 0 : i0 + 1;
        m = '0; m[i0] = 1'b1; m[i1] = 1'b1;
        refill(m); arm();
        run_frame(50, 16'd16, 100, "R8 full");
        // R7 R9: random frames around the ring
        for (int n = 0; n < 30; n++) begin
            refill((n % 5 == 4) ? RING_N'($urandom) : '1);
            arm();
            run_frame(int'($urandom % 76), 16'($urandom) & 16'hC07F,
                      8 + int'($urandom % 80), "R7 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule